// File: doc/BRIEF.md
# Raster Timing Chain with Gated Motion Burst

This block produces all raster timing for a display from one reference clock running at twice the pixel rate. A phase flop halves the reference to form the pixel clock. A horizontal chain counts 384 pixel periods per scan line. A vertical chain counts 272 lines per frame. Decoded taps of the two chains give horizontal and vertical sync and blanking. A one-count pulse marks the end of each line.

A second clock output carries a burst of exactly 255 consecutive pixel-clock pulses at the start of every line and stays low for the other 129 counts. Downstream object-motion counters are clocked from this burst. After reset the block holds itself idle for a fixed number of reference cycles, and then starts both chains from count zero. This gives the vertical chain a known start.

Each part is a small named state machine:
- Start-up machine: `ST_HOLD` moves to `ST_RUN` when its hold counter expires. Reset sends it back to `ST_HOLD`.
- Horizontal machine: `HZ_ACTIVE` → `HZ_FRONT` → `HZ_SYNC` → `HZ_BACK` → `HZ_ACTIVE`. Each move happens on the pixel tick that ends the last count of the current region.
- Vertical machine: `VT_ACTIVE` → `VT_FRONT` → `VT_SYNC` → `VT_BACK` → `VT_ACTIVE`. Each move happens at the line boundary that ends the region.

Top module: `raster_timer`

## Requirements
- R1: While running, `pix_clk` toggles on every reference clock edge, giving a square wave at half the reference rate.
- R2: A line lasts 384 pixel counts (768 reference cycles); `hreset` is high during count 383 only (two reference cycles) and the count wraps to 0 after it.
- R3: `motion_clk` is high only in the high half of `pix_clk` during counts 0 to 254, giving exactly 255 pulses per line, and is low for counts 255 to 383.
- R4: `hblank` is high for counts 256 to 383 and `hsync` for counts 288 to 319; both are low elsewhere.
- R5: A frame lasts 272 lines; `vblank` is high for lines 240 to 271 and `vsync` for lines 248 to 251, and both change only at line boundaries.
- R6: `rst` is synchronous and active high; the edge that samples it high drives every output to 0.
- R7: After `rst` is released, all outputs stay 0 for 16 reference edges and `pix_clk` first reads 1 after the 17th edge.
- R8: After start-up both chains begin at count 0 and line 0, so `vblank` is first seen 16 + 768·240 = 184336 reference cycles after reset release and `vsync` at 190480.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | output | 1 | Pixel clock, reference divided by two |
| motion_clk | output | 1 | 255-pulse gated pixel clock per line |
| hreset | output | 1 | High during the last count of each line |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blanking |
| vsync | output | 1 | Vertical sync |
| vblank | output | 1 | Vertical blanking |

## Verification
The vertical taps are the hard part to reach from the ports. At the default sizes the first vertical blank comes about 184 thousand reference cycles after reset, and a full frame takes longer than a short run allows. The stimulus therefore drives a second instance built with a shrunken line and frame. On that instance it measures the whole frame, the sync width and the blank onset. The full-size instance gets one long run from a mid-line reset, which pins the exact cycle of its first vertical blank and first vertical sync.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Default geometry, in pixel counts and lines
    localparam int DEF_H_TOTAL   = 384;
    localparam int DEF_H_ACT     = 256;
    localparam int DEF_HS_START  = 288;
    localparam int DEF_HS_END    = 320;
    localparam int DEF_BURST_LEN = 255;
    localparam int DEF_V_TOTAL   = 272;
    localparam int DEF_V_ACT     = 240;
    localparam int DEF_VS_START  = 248;
    localparam int DEF_VS_END    = 252;
    localparam int DEF_HOLD_CYC  = 16;

    typedef enum logic {
        ST_HOLD,
        ST_RUN
    } start_state_t;

    typedef enum logic [1:0] {
        HZ_ACTIVE,
        HZ_FRONT,
        HZ_SYNC,
        HZ_BACK
    } hz_state_t;

    typedef enum logic [1:0] {
        VT_ACTIVE,
        VT_FRONT,
        VT_SYNC,
        VT_BACK
    } vt_state_t;

endpackage

// File: rtl/rt_startup.sv
module rt_startup
    import raster_pkg::*;
#(
    parameter int HOLD_CYC = DEF_HOLD_CYC
) (
    input  logic clk,
    input  logic rst,
    output logic rst_any
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    start_state_t st, st_nx;
    logic [CW-1:0] hold_cnt;

    // State register and hold counter
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_HOLD;
            hold_cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_HOLD) begin
                hold_cnt <= hold_cnt + 1'b1;
            end else begin
                hold_cnt <= '0;
            end
        end
    end

    // Transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HOLD: if (hold_cnt == HOLD_LAST) st_nx = ST_RUN;
            ST_RUN:  st_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        rst_any = rst || (st == ST_HOLD);
    end

    assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && hold_cnt != HOLD_LAST) |=> (st == ST_HOLD));

    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |=> (st == ST_RUN));

    assert_hold_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (hold_cnt < CW'(HOLD_CYC)));

endmodule

// File: rtl/rt_phase.sv
module rt_phase (
    input  logic clk,
    input  logic rst_any,
    output logic ph
);
    // ph low: first half of a pixel count, ph high: second half.
    // The edge that sees ph high ends the current count.
    always_ff @(posedge clk) begin
        if (rst_any) begin
            ph <= 1'b0;
        end else begin
            ph <= ~ph;
        end
    end

    assert_toggle_R1: assert property (@(posedge clk) disable iff (rst_any)
        !rst_any |=> (ph != $past(ph)));

endmodule

// File: rtl/rt_hchain.sv
module rt_hchain
    import raster_pkg::*;
#(
    parameter int H_TOTAL   = DEF_H_TOTAL,
    parameter int H_ACT     = DEF_H_ACT,
    parameter int HS_START  = DEF_HS_START,
    parameter int HS_END    = DEF_HS_END,
    parameter int BURST_LEN = DEF_BURST_LEN
) (
    input  logic clk,
    input  logic rst_any,
    input  logic ph,
    output logic line_adv,
    output logic hreset,
    output logic hsync,
    output logic hblank,
    output logic motion_clk
);
    localparam int HW = $clog2(H_TOTAL);
    localparam logic [HW-1:0] LAST_CNT  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] ACT_LAST  = HW'(H_ACT - 1);
    localparam logic [HW-1:0] FRT_LAST  = HW'(HS_START - 1);
    localparam logic [HW-1:0] SYN_LAST  = HW'(HS_END - 1);
    localparam logic [HW-1:0] SYN_FIRST = HW'(HS_START);
    localparam logic [HW-1:0] SYN_LIM   = HW'(HS_END);
    localparam logic [HW-1:0] BURST_LIM = HW'(BURST_LEN);

    hz_state_t st, st_nx;
    logic [HW-1:0] cnt;
    logic at_end;

    always_comb at_end = (cnt == LAST_CNT);

    // State register and pixel counter, stepping once per pixel
    always_ff @(posedge clk) begin
        if (rst_any) begin
            st  <= HZ_ACTIVE;
            cnt <= '0;
        end else if (ph) begin
            st <= st_nx;
            if (at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Transitions at the last count of each region
    always_comb begin
        st_nx = st;
        unique case (st)
            HZ_ACTIVE: if (cnt == ACT_LAST) st_nx = HZ_FRONT;
            HZ_FRONT:  if (cnt == FRT_LAST) st_nx = HZ_SYNC;
            HZ_SYNC:   if (cnt == SYN_LAST) st_nx = HZ_BACK;
            HZ_BACK:   if (at_end)          st_nx = HZ_ACTIVE;
        endcase
    end

    // Decoded outputs
    always_comb begin
        hblank   = (st != HZ_ACTIVE);
        hsync    = (st == HZ_SYNC);
        hreset   = (st == HZ_BACK) && at_end;
        line_adv = ph && at_end;
    end

    // Burst: registered so it follows the high half of the pixel clock
    always_ff @(posedge clk) begin
        if (rst_any) begin
            motion_clk <= 1'b0;
        end else begin
            motion_clk <= !ph && (cnt < BURST_LIM);
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst_any)
        (ph && !at_end) |=> (cnt == $past(cnt) + 1'b1));

    assert_count_wrap_R2: assert property (@(posedge clk) disable iff (rst_any)
        (ph && at_end) |=> (cnt == '0 && st == HZ_ACTIVE));

    assert_sync_window_R4: assert property (@(posedge clk) disable iff (rst_any)
        (st == HZ_SYNC) |-> (cnt >= SYN_FIRST && cnt < SYN_LIM));

    assert_sync_in_blank_R4: assert property (@(posedge clk) disable iff (rst_any)
        hsync |-> hblank);

    assert_burst_active_R3: assert property (@(posedge clk) disable iff (rst_any)
        motion_clk |-> !hblank);

endmodule

// File: rtl/rt_vchain.sv
module rt_vchain
    import raster_pkg::*;
#(
    parameter int V_TOTAL  = DEF_V_TOTAL,
    parameter int V_ACT    = DEF_V_ACT,
    parameter int VS_START = DEF_VS_START,
    parameter int VS_END   = DEF_VS_END
) (
    input  logic clk,
    input  logic rst_any,
    input  logic adv,
    output logic vsync,
    output logic vblank
);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [VW-1:0] LAST_LN   = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] ACT_LAST  = VW'(V_ACT - 1);
    localparam logic [VW-1:0] FRT_LAST  = VW'(VS_START - 1);
    localparam logic [VW-1:0] SYN_LAST  = VW'(VS_END - 1);
    localparam logic [VW-1:0] SYN_FIRST = VW'(VS_START);
    localparam logic [VW-1:0] SYN_LIM   = VW'(VS_END);

    vt_state_t st, st_nx;
    logic [VW-1:0] line;
    logic at_end;

    always_comb at_end = (line == LAST_LN);

    // State register and line counter, stepping at each line end
    always_ff @(posedge clk) begin
        if (rst_any) begin
            st   <= VT_ACTIVE;
            line <= '0;
        end else if (adv) begin
            st <= st_nx;
            if (at_end) begin
                line <= '0;
            end else begin
                line <= line + 1'b1;
            end
        end
    end

    // Transitions at the last line of each region
    always_comb begin
        st_nx = st;
        unique case (st)
            VT_ACTIVE: if (line == ACT_LAST) st_nx = VT_FRONT;
            VT_FRONT:  if (line == FRT_LAST) st_nx = VT_SYNC;
            VT_SYNC:   if (line == SYN_LAST) st_nx = VT_BACK;
            VT_BACK:   if (at_end)           st_nx = VT_ACTIVE;
        endcase
    end

    // Decoded outputs
    always_comb begin
        vblank = (st != VT_ACTIVE);
        vsync  = (st == VT_SYNC);
    end

    assert_line_step_R5: assert property (@(posedge clk) disable iff (rst_any)
        (adv && !at_end) |=> (line == $past(line) + 1'b1));

    assert_line_hold_R5: assert property (@(posedge clk) disable iff (rst_any)
        !adv |=> $stable(line));

    assert_frame_bound_R5: assert property (@(posedge clk) disable iff (rst_any)
        line <= LAST_LN);

    assert_vsync_window_R5: assert property (@(posedge clk) disable iff (rst_any)
        (st == VT_SYNC) |-> (line >= SYN_FIRST && line < SYN_LIM));

    assert_vsync_in_vblank_R5: assert property (@(posedge clk) disable iff (rst_any)
        vsync |-> vblank);

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int H_TOTAL   = DEF_H_TOTAL,
    parameter int H_ACT     = DEF_H_ACT,
    parameter int HS_START  = DEF_HS_START,
    parameter int HS_END    = DEF_HS_END,
    parameter int BURST_LEN = DEF_BURST_LEN,
    parameter int V_TOTAL   = DEF_V_TOTAL,
    parameter int V_ACT     = DEF_V_ACT,
    parameter int VS_START  = DEF_VS_START,
    parameter int VS_END    = DEF_VS_END,
    parameter int HOLD_CYC  = DEF_HOLD_CYC
) (
    input  logic clk_ref,
    input  logic rst,
    output logic pix_clk,
    output logic motion_clk,
    output logic hreset,
    output logic hsync,
    output logic hblank,
    output logic vsync,
    output logic vblank
);
    logic rst_any;
    logic ph;
    logic line_adv;

    rt_startup #(
        .HOLD_CYC (HOLD_CYC)
    ) u_startup (
        .clk     (clk_ref),
        .rst     (rst),
        .rst_any (rst_any)
    );

    rt_phase u_phase (
        .clk     (clk_ref),
        .rst_any (rst_any),
        .ph      (ph)
    );

    rt_hchain #(
        .H_TOTAL   (H_TOTAL),
        .H_ACT     (H_ACT),
        .HS_START  (HS_START),
        .HS_END    (HS_END),
        .BURST_LEN (BURST_LEN)
    ) u_hchain (
        .clk        (clk_ref),
        .rst_any    (rst_any),
        .ph         (ph),
        .line_adv   (line_adv),
        .hreset     (hreset),
        .hsync      (hsync),
        .hblank     (hblank),
        .motion_clk (motion_clk)
    );

    rt_vchain #(
        .V_TOTAL  (V_TOTAL),
        .V_ACT    (V_ACT),
        .VS_START (VS_START),
        .VS_END   (VS_END)
    ) u_vchain (
        .clk     (clk_ref),
        .rst_any (rst_any),
        .adv     (line_adv),
        .vsync   (vsync),
        .vblank  (vblank)
    );

    always_comb pix_clk = ph;

    assert_burst_in_high_R3: assert property (@(posedge clk_ref) disable iff (rst_any)
        motion_clk |-> pix_clk);

    assert_hreset_in_blank_R2: assert property (@(posedge clk_ref) disable iff (rst_any)
        hreset |-> hblank);

    assert_reset_clears_R6: assert property (@(posedge clk_ref)
        rst |=> (!pix_clk && !motion_clk && !hblank && !vblank));

endmodule

// File: tb/raster_timer_test.sv
`timescale 1ns/1ps
module raster_timer_test;

    localparam int LINE_CYC = 768;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic pix, mot, hres, hs, hb, vs, vb;
    logic s_pix, s_mot, s_hres, s_hs, s_hb, s_vs, s_vb;

    raster_timer uut (
        .clk_ref (clk), .rst (rst),
        .pix_clk (pix), .motion_clk (mot), .hreset (hres),
        .hsync (hs), .hblank (hb), .vsync (vs), .vblank (vb)
    );

    // Shrunken geometry: 24-count lines, 12-line frames
    raster_timer #(
        .H_TOTAL (24), .H_ACT (16), .HS_START (18), .HS_END (20), .BURST_LEN (15),
        .V_TOTAL (12), .V_ACT (8), .VS_START (9), .VS_END (10), .HOLD_CYC (16)
    ) uut_small (
        .clk_ref (clk), .rst (rst),
        .pix_clk (s_pix), .motion_clk (s_mot), .hreset (s_hres),
        .hsync (s_hs), .hblank (s_hb), .vsync (s_vs), .vblank (s_vb)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int outs_big();
        return int'({pix, mot, hres, hs, hb, vs, vb});
    endfunction

    function automatic int outs_small();
        return int'({s_pix, s_mot, s_hres, s_hs, s_hb, s_vs, s_vb});
    endfunction

    // R6, R7: reset state and the start-up hold
    task automatic t_reset_hold();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(outs_big() == 0, "R6", "outputs in reset", outs_big(), 0);
        check(outs_small() == 0, "R6", "small outputs in reset", outs_small(), 0);
        rst = 1'b0;
        for (int n = 1; n <= 17; n++) begin
            @(negedge clk);
            if (n <= 16) begin
                check(outs_big() == 0, "R7", "outputs during hold", outs_big(), 0);
            end else begin
                check(pix == 1'b1, "R7", "first pixel clock high", int'(pix), 1);
            end
        end
    endtask

    // R1: pixel clock toggles every reference cycle
    task automatic t_pix_toggle();
        logic prev;
        prev = pix;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            check(pix != prev, "R1", "pix_clk toggle", int'(pix), int'(!prev));
            prev = pix;
        end
    endtask

    // R2, R3, R4: one full line scanned cycle by cycle
    task automatic t_line_scan();
        int rises;
        int hr_cyc;
        logic pm;
        rises  = 0;
        hr_cyc = 0;
        pm     = 1'b0;
        while (!hres) @(negedge clk);
        while (hres)  @(negedge clk);
        for (int i = 0; i < LINE_CYC; i++) begin
            int k;
            bit odd;
            k   = i / 2;
            odd = (i % 2) == 1;
            check(pix == odd, "R1", "pix_clk phase in line", int'(pix), int'(odd));
            check(mot == (odd && k <= 254), "R3", "motion_clk", int'(mot),
                  int'(odd && k <= 254));
            check(hb == (k >= 256), "R4", "hblank", int'(hb), int'(k >= 256));
            check(hs == (k >= 288 && k < 320), "R4", "hsync", int'(hs),
                  int'(k >= 288 && k < 320));
            check(hres == (k == 383), "R2", "hreset", int'(hres), int'(k == 383));
            if (mot && !pm) rises++;
            pm = mot;
            if (hres) hr_cyc++;
            @(negedge clk);
        end
        check(rises == 255, "R3", "burst pulses per line", rises, 255);
        check(hr_cyc == 2, "R2", "hreset width in cycles", hr_cyc, 2);
        check(!hb && !hres, "R2", "line wraps to count 0", int'({hb, hres}), 0);
    endtask

    // R5: frame structure on the shrunken instance
    task automatic t_small_frame();
        logic pv, pvb, phr;
        int vs_hi, vb_hi, lines, vb_rise_at;
        vs_hi = 0; vb_hi = 0; lines = 0; vb_rise_at = -1;
        pv = s_vs;
        @(negedge clk);
        while (!(s_vs && !pv)) begin
            pv = s_vs;
            @(negedge clk);
        end
        pvb = s_vb;
        phr = s_hres;
        for (int i = 0; i < 576; i++) begin
            if (s_vs) vs_hi++;
            if (s_vb) vb_hi++;
            if (s_vb && !pvb) vb_rise_at = i;
            if (s_hres && !phr) lines++;
            pvb = s_vb;
            phr = s_hres;
            pv  = s_vs;
            @(negedge clk);
        end
        check(s_vs && !pv, "R5", "vsync period 12 lines", int'({s_vs, pv}), 2);
        check(vs_hi == 48, "R5", "vsync width cycles", vs_hi, 48);
        check(vb_hi == 192, "R5", "vblank width cycles", vb_hi, 192);
        check(vb_rise_at == 528, "R5", "vblank onset before vsync", vb_rise_at, 528);
        check(lines == 12, "R5", "lines per frame", lines, 12);
    endtask

    // R6 mid-line, then R8/R5 on the full-size frame
    task automatic t_long_frame();
        int n;
        int vb_at;
        while (!hb) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(outs_big() == 0, "R6", "outputs after mid-line reset", outs_big(), 0);
        check(outs_small() == 0, "R6", "small outputs after reset", outs_small(), 0);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        vb_at = -1;
        while (!vs && n < 195000) begin
            @(negedge clk);
            n++;
            if (vb && vb_at < 0) begin
                vb_at = n;
                check(!vs, "R5", "vsync low at vblank onset", int'(vs), 0);
            end
        end
        check(vb_at == 184336, "R8", "first vblank cycle", vb_at, 184336);
        check(n == 190480, "R8", "first vsync cycle", n, 190480);
        check(vb, "R5", "vblank high during vsync", int'(vb), 1);
    endtask

    initial begin
        t_reset_hold();
        t_pix_toggle();
        t_line_scan();
        t_small_frame();
        t_long_frame();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (199500) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..: actual %0d cycles expected completion", 199500);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule